// File: doc/BRIEF.md
# Dual-Sample ADC Read Sequencer

This block is the SPI master for a two-channel, simultaneously sampling 12-bit converter. Nothing but frame length sets the converter's power state. A frame of at least two bytes brings it out of power-down, and a frame of one byte sends it back. A single request therefore runs as three separate chip-select windows: a 16-clock wake frame, a 32-clock data frame and an 8-clock sleep frame. Chip select goes high between the windows.

When a request is accepted, the block latches the channel number, the input mode and the range flag. It then drives a three-bit channel address to the converter's multiplexer. The mode sets how the address is formed from the channel number. A fixed-address option leaves the address pins untouched. The data frame carries two 16-bit words, most significant bit first. In each word the 12-bit result sits two bits above the bottom. The block extracts both results and extends them to the output width. The extension is sign extension when the configuration gives signed codes and zero fill otherwise. It also reports the result of the word chosen by the channel number's lowest bit. The results come with a one-cycle valid pulse at the moment the sequence ends.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, csN and sclk are high, busy and resValid are low, and addrOut is 0.
- R2: An accepted request produces exactly three chip-select-low windows, in this order: 16, 32 and 8 falling sclk edges. csN is high between windows and whenever busy is low.
- R3: When fixedAddr is low at acceptance, addrOut is loaded from chanIdx according to inMode. Code 0 (single-ended) and code 3 give chanIdx shifted right by one. Code 1 (pseudo-differential) gives chanIdx with bit 0 forced to 1. Code 2 (fully differential) gives chanIdx with bit 0 cleared. In every case only the low three bits are kept. addrOut changes at no other time.
- R4: When fixedAddr is high at acceptance, addrOut keeps its previous value.
- R5: Of the 32 bits in the data frame, the first 16 received form word A and the last 16 form word B. Each result is bits 13 down to 2 of its word, presented on resA and resB.
- R6: A result is sign-extended from its bit 11 to 16 bits when inMode is 2 or wideRange is high at acceptance. Otherwise it is zero-extended.
- R7: resSel equals resB when bit 0 of the accepted chanIdx is 1, and resA otherwise.
- R8: busy rises in the cycle after startReq is accepted in idle and stays high until the sleep frame and its trailing gap finish. A startReq while busy is ignored: it changes neither the sequence, the address nor the results.
- R9: resValid is high for exactly one cycle, in the first cycle with busy low after a sequence. resA, resB and resSel are valid from that cycle on.
- R10: sclk idles high. Each bit starts with a falling edge, at which miso is sampled. The sclk period is 2×HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request strobe, taken only when idle |
| chanIdx | input | 4 | Requested channel number |
| inMode | input | 2 | Input mode: 0 single-ended, 1 pseudo-differential, 2 fully differential, 3 as 0 |
| wideRange | input | 1 | Range is twice the reference (signed codes) |
| fixedAddr | input | 1 | Address pins are not driven by requests |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| addrOut | output | 3 | Channel address to converter |
| busy | output | 1 | Sequence in progress |
| resA | output | 16 | Extended result of word A |
| resB | output | 16 | Extended result of word B |
| resSel | output | 16 | Result chosen by chanIdx bit 0 |
| resValid | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that rstN is held low for at least one clock edge. They also assume that startReq, fixedAddr and the other configuration inputs change only away from the rising clock edge. The address checks compare addrOut against the previous cycle's fixedAddr, so they depend on fixedAddr being steady at the edge where a request is accepted. The bench drives every input at the falling clock edge and holds the configuration steady across the accepting edge. It sweeps every mode code against both range settings and the channel numbers 0 to 11, and it injects a conflicting request in the middle of a sequence to probe R8.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PSEUDO = 2'd1,
    MODE_DIFF   = 2'd2,
    MODE_RSVD   = 2'd3
  } inMode_e;

  typedef enum logic [1:0] {
    FR_WAKE  = 2'd0,
    FR_DATA  = 2'd1,
    FR_SLEEP = 2'd2
  } frameSel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FRAME = 2'd1,
    SEQ_GAP   = 2'd2
  } seqState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeCmd;    // request accepted this cycle
    logic sampleBit;  // shift miso in (data frame only)
    logic grabWords;  // data frame complete
    logic finish;     // sleep frame and its gap complete
  } ctrlStrobe_t;

endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int GAP_CLKS  = 4,
  parameter int WAKE_BITS = 16,
  parameter int DATA_BITS = 32,
  parameter int PD_BITS   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output ctrlStrobe_t strobe,
  output logic        sclk,
  output logic        csN,
  output logic        busy
);

  localparam int CNT_MAX  = (HALF_DIV > GAP_CLKS) ? HALF_DIV : GAP_CLKS;
  localparam int DIV_W    = $clog2(CNT_MAX + 1);
  localparam int MAX_BITS = (DATA_BITS > WAKE_BITS) ?
                            ((DATA_BITS > PD_BITS) ? DATA_BITS : PD_BITS) :
                            ((WAKE_BITS > PD_BITS) ? WAKE_BITS : PD_BITS);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GAP_LAST  = DIV_W'(GAP_CLKS - 1);

  seqState_e        seqState;
  frameSel_e        frameSel;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] frameBits;
  logic             halfDone;
  logic             gapDone;
  logic             allBits;

  always_comb begin
    unique case (frameSel)
      FR_WAKE: frameBits = BIT_W'(WAKE_BITS);
      FR_DATA: frameBits = BIT_W'(DATA_BITS);
      default: frameBits = BIT_W'(PD_BITS);
    endcase
  end

  assign halfDone = (divCnt == HALF_LAST);
  assign gapDone  = (divCnt == GAP_LAST);
  assign allBits  = (bitCnt == frameBits);

  always_comb begin
    strobe.takeCmd   = (seqState == SEQ_IDLE) && startReq;
    strobe.sampleBit = (seqState == SEQ_FRAME) && (frameSel == FR_DATA) &&
                       halfDone && sclk && !allBits;
    strobe.grabWords = (seqState == SEQ_FRAME) && (frameSel == FR_DATA) &&
                       halfDone && sclk && allBits;
    strobe.finish    = (seqState == SEQ_GAP) && (frameSel == FR_SLEEP) && gapDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      frameSel <= FR_WAKE;
      divCnt   <= '0;
      bitCnt   <= '0;
      sclk     <= 1'b1;
      csN      <= 1'b1;
      busy     <= 1'b0;
    end else begin
      unique case (seqState)
        SEQ_IDLE: begin
          if (startReq) begin
            busy     <= 1'b1;
            csN      <= 1'b0;
            frameSel <= FR_WAKE;
            divCnt   <= '0;
            bitCnt   <= '0;
            seqState <= SEQ_FRAME;
          end
        end
        SEQ_FRAME: begin
          if (halfDone) begin
            divCnt <= '0;
            if (sclk) begin
              if (allBits) begin
                csN      <= 1'b1;
                seqState <= SEQ_GAP;
              end else begin
                sclk <= 1'b0;
              end
            end else begin
              sclk   <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (gapDone) begin
            divCnt <= '0;
            if (frameSel == FR_SLEEP) begin
              busy     <= 1'b0;
              seqState <= SEQ_IDLE;
            end else begin
              frameSel <= (frameSel == FR_WAKE) ? FR_DATA : FR_SLEEP;
              bitCnt   <= '0;
              csN      <= 1'b0;
              seqState <= SEQ_FRAME;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: seqState <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter int CHAN_W    = 4,
  parameter int ADDR_W    = 3,
  parameter int WORD_W    = 16,
  parameter int RES_W     = 12,
  parameter int FIELD_LSB = 2,
  parameter int OUT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              miso,
  input  logic [CHAN_W-1:0] chanIdx,
  input  inMode_e           inMode,
  input  logic              wideRange,
  input  logic              fixedAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic [OUT_W-1:0]  resA,
  output logic [OUT_W-1:0]  resB,
  output logic [OUT_W-1:0]  resSel,
  output logic              resValid
);

  localparam int LANES   = 2;
  localparam int SHIFT_W = LANES * WORD_W;
  localparam int PAD_W   = OUT_W - RES_W;

  logic [CHAN_W-1:0]            chanQ;
  logic                         signQ;
  logic [SHIFT_W-1:0]           shiftReg;
  logic [CHAN_W-1:0]            chanMapped;
  logic [LANES-1:0][OUT_W-1:0]  decWord;

  // Multiplexer address from the channel number, per input mode
  always_comb begin
    unique case (inMode)
      MODE_PSEUDO: chanMapped = chanIdx | CHAN_W'(1);
      MODE_DIFF:   chanMapped = chanIdx & ~CHAN_W'(1);
      default:     chanMapped = chanIdx >> 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ    <= '0;
      signQ    <= 1'b0;
      addrOut  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.takeCmd) begin
        chanQ <= chanIdx;
        signQ <= (inMode == MODE_DIFF) || wideRange;
        if (!fixedAddr) addrOut <= chanMapped[ADDR_W-1:0];
      end
      if (strobe.sampleBit) shiftReg <= {shiftReg[SHIFT_W-2:0], miso};
    end
  end

  // One lane per received word; word A arrives first (upper half)
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [WORD_W-1:0] capQ;
    logic [RES_W-1:0]  field;

    always_ff @(posedge clk) begin
      if (!rstN)                 capQ <= '0;
      else if (strobe.grabWords) capQ <= shiftReg[(LANES-1-lane)*WORD_W +: WORD_W];
    end

    assign field = capQ[FIELD_LSB +: RES_W];
    assign decWord[lane] = signQ ? {{PAD_W{field[RES_W-1]}}, field}
                                 : {{PAD_W{1'b0}}, field};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resA     <= '0;
      resB     <= '0;
      resSel   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobe.finish;
      if (strobe.finish) begin
        resA   <= decWord[0];
        resB   <= decWord[1];
        resSel <= chanQ[0] ? decWord[1] : decWord[0];
      end
    end
  end

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import adcrd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CLKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [3:0]  chanIdx,
  input  logic [1:0]  inMode,
  input  logic        wideRange,
  input  logic        fixedAddr,
  input  logic        miso,
  output logic        sclk,
  output logic        csN,
  output logic [2:0]  addrOut,
  output logic        busy,
  output logic [15:0] resA,
  output logic [15:0] resB,
  output logic [15:0] resSel,
  output logic        resValid
);

  ctrlStrobe_t ctrlStb;

  adcrd_ctrl #(
    .HALF_DIV (HALF_DIV),
    .GAP_CLKS (GAP_CLKS),
    .WAKE_BITS(16),
    .DATA_BITS(32),
    .PD_BITS  (8)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .strobe  (ctrlStb),
    .sclk    (sclk),
    .csN     (csN),
    .busy    (busy)
  );

  adcrd_datapath #(
    .CHAN_W   (4),
    .ADDR_W   (3),
    .WORD_W   (16),
    .RES_W    (12),
    .FIELD_LSB(2),
    .OUT_W    (16)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctrlStb),
    .miso     (miso),
    .chanIdx  (chanIdx),
    .inMode   (inMode_e'(inMode)),
    .wideRange(wideRange),
    .fixedAddr(fixedAddr),
    .addrOut  (addrOut),
    .resA     (resA),
    .resB     (resB),
    .resSel   (resSel),
    .resValid (resValid)
  );

endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       fixedAddr,
  input logic       busy,
  input logic       csN,
  input logic       sclk,
  input logic [2:0] addrOut,
  input logic       resValid
);

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  assert_addr_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrOut) |-> $past(startReq && !busy));

  assert_addr_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(fixedAddr) |-> $stable(addrOut));

  assert_busy_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !csN) |=> busy);

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_valid_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (!busy && $past(busy)));

endmodule

bind dual_adc_reader adcrd_checker u_adcrd_checker (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .fixedAddr(fixedAddr),
  .busy     (busy),
  .csN      (csN),
  .sclk     (sclk),
  .addrOut  (addrOut),
  .resValid (resValid)
);

// File: tb/test_dual_adc_reader.sv
module test_dual_adc_reader;

  localparam int HALF_DIV = 2;
  localparam int CLK_NS   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [3:0]  chanIdx = '0;
  logic [1:0]  inMode = '0;
  logic        wideRange = 1'b0;
  logic        fixedAddr = 1'b0;
  logic        miso;
  logic        sclk, csN, busy, resValid;
  logic [2:0]  addrOut;
  logic [15:0] resA, resB, resSel;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] slaveWord = '0;
  int curBits = 0;
  int frameCnt = 0;
  int frameLens[8];
  int periodErr = 0;
  time lastFall = 0;
  logic [2:0] expAddr = '0;

  always #(CLK_NS/2) clk = ~clk;

  dual_adc_reader #(.HALF_DIV(HALF_DIV), .GAP_CLKS(4)) i_dual_adc_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanIdx(chanIdx),
    .inMode(inMode), .wideRange(wideRange), .fixedAddr(fixedAddr),
    .miso(miso), .sclk(sclk), .csN(csN), .addrOut(addrOut), .busy(busy),
    .resA(resA), .resB(resB), .resSel(resSel), .resValid(resValid)
  );

  // Converter model: presents bit (31 - curBits) of slaveWord, MSB first
  assign miso = (curBits < 32) ? slaveWord[31 - curBits] : 1'b0;

  always @(negedge sclk or negedge csN) begin
    if (sclk === 1'b1) begin
      curBits = 0;
    end else if (csN === 1'b0) begin
      if (curBits > 0 && ($time - lastFall) != 2 * HALF_DIV * CLK_NS) periodErr++;
      lastFall = $time;
      curBits++;
    end
  end

  always @(posedge csN) begin
    if (frameCnt < 8) frameLens[frameCnt] = curBits;
    frameCnt++;
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog R2: cycles=%0d expected below 190000", cycles);
      finishRun();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] decode(input logic [15:0] w, input logic sgn);
    logic [11:0] r;
    r = 12'((w >> 2) & 16'h0FFF);
    return sgn ? {{4{r[11]}}, r} : {4'h0, r};
  endfunction

  function automatic logic [2:0] mapAddr(input logic [3:0] ch, input logic [1:0] md);
    case (md)
      2'd1:    return 3'(ch | 4'd1);
      2'd2:    return 3'(ch & 4'hE);
      default: return 3'(ch >> 1);
    endcase
  endfunction

  task automatic runOne(input logic [3:0] ch, input logic [1:0] md, input logic wide,
                        input logic fix, input logic [31:0] word, input bit probe);
    logic sgn;
    int   waitCnt;
    sgn = (md == 2'd2) || wide;
    if (!fix) expAddr = mapAddr(ch, md);
    @(negedge clk);
    slaveWord = word;
    frameCnt  = 0;
    periodErr = 0;
    chanIdx = ch; inMode = md; wideRange = wide; fixedAddr = fix;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R8 busy after start", 32'(busy), 32'd1);
    if (probe) begin
      repeat (60) @(negedge clk);
      // conflicting request while busy must be ignored (R8)
      chanIdx = ~ch; inMode = 2'd1; wideRange = ~wide; fixedAddr = 1'b0;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      @(negedge clk);
      check("R8 addr unchanged by ignored start", 32'(addrOut), 32'(expAddr));
      fixedAddr = fix;
    end
    waitCnt = 0;
    while (resValid !== 1'b1) begin
      @(negedge clk);
      waitCnt++;
      if (waitCnt > 5000) begin
        bad++; total++;
        $display("FAIL R9 no valid: actual=0 expected=1");
        finishRun();
      end
    end
    check("R9 busy low at valid", 32'(busy), 32'd0);
    check("R5/R6 resA", 32'(resA), 32'(decode(word[31:16], sgn)));
    check("R5/R6 resB", 32'(resB), 32'(decode(word[15:0], sgn)));
    check("R7 resSel", 32'(resSel),
          32'(ch[0] ? decode(word[15:0], sgn) : decode(word[31:16], sgn)));
    check(fix ? "R4 addr held" : "R3 addr mapped", 32'(addrOut), 32'(expAddr));
    check("R2 frame count", 32'(frameCnt), 32'd3);
    check("R2 wake frame bits", 32'(frameLens[0]), 32'd16);
    check("R2 data frame bits", 32'(frameLens[1]), 32'd32);
    check("R2 sleep frame bits", 32'(frameLens[2]), 32'd8);
    check("R10 sclk period", 32'(periodErr), 32'd0);
    @(negedge clk);
    check("R9 valid one cycle", 32'(resValid), 32'd0);
    check("R2 cs high when idle", 32'(csN), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 csN reset", 32'(csN), 32'd1);
    check("R1 sclk reset", 32'(sclk), 32'd1);
    check("R1 busy reset", 32'(busy), 32'd0);
    check("R1 valid reset", 32'(resValid), 32'd0);
    check("R1 addr reset", 32'(addrOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // fixed address from reset, boundary words
    runOne(4'd7, 2'd0, 1'b0, 1'b1, {16'h8000, 16'h7FFF}, 1'b0);
    runOne(4'd10, 2'd2, 1'b0, 1'b1, {16'h2000, 16'hDFFC}, 1'b0);
    runOne(4'd3, 2'd0, 1'b1, 1'b1, {16'hFFFF, 16'h0003}, 1'b0);

    // full sweep of mode, range and channel
    for (int md = 0; md < 4; md++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int ch = 0; ch < 12; ch++) begin
          logic [15:0] wA;
          logic [15:0] wB;
          wA = 16'((md * 24 + wd * 12 + ch) * 16'h2D3B + 16'h1004);
          wB = ~wA ^ 16'(ch << 9);
          runOne(4'(ch), 2'(md), wd[0], 1'b0, {wA, wB}, 1'b0);
        end
      end
    end

    // fixed address after a mapped one keeps the last value
    runOne(4'd0, 2'd1, 1'b0, 1'b1, {16'h5554, 16'hAAA8}, 1'b0);
    // ignored request mid-sequence
    runOne(4'd5, 2'd0, 1'b0, 1'b0, {16'h9ABC, 16'h1234}, 1'b1);
    runOne(4'd8, 2'd2, 1'b1, 1'b0, {16'h7FFC, 16'h8000}, 1'b1);

    finishRun();
  end

endmodule